// File: doc/BRIEF.md
# Multi-Channel Prescaled PWM Controller

This block drives one pulse-width-modulated output pin per channel. Each channel has one 32-bit control word on a small memory-mapped write/read bus. The word holds three fields: a run bit, a high-time count and a clock divider. The divider turns the input clock into ticks, each lasting divider+1 clocks. A frame is always 256 ticks long. The output is high for the first high-time ticks of every frame and low for the rest.

Channel registers sit 16 bytes apart. A write lands in the channel register on the clock edge that samples it. Reads are combinational from the address. A running channel keeps its current high-time and divider until its frame ends, so a reprogrammed waveform never produces a shortened or stretched pulse. Software sets the period through the divider alone, because the frame length is fixed. It sets the duty in 1/256 steps.

Top module: `pwm_bank`

## Requirements
- R1: A channel word reads back as written, masked to its fields: run bit at bit 31, high-time count at bits 24:16 (9 bits), divider at bits 12:0 (13 bits). All other bits read as zero.
- R2: Channel n is at byte address n*16. A write to an address whose low four bits are not zero, or whose channel number is NCH or more, changes no register. A read of such an address returns zero.
- R3: While the run bit is clear, the output is low and the tick and frame counters are held at zero. A write that clears the run bit drops the output immediately after the write edge, and the next enable restarts the frame at tick 0.
- R4: Each tick lasts divider+1 input clocks, so the frame period is 256*(divider+1) clocks.
- R5: The output is high during ticks 0 to D-1 of a frame, where D is the high-time count. D=0 gives a constant low output. D of 256 or more gives a constant high output.
- R6: A write that sets the run bit on a stopped channel at edge E leaves the output low after E. Tick 0 of the first frame begins after edge E+1.
- R7: A high-time or divider written while the channel runs takes effect only at the start of the next frame.
- R8: Writing 0 to a channel stops it and clears its high-time and divider.
- R9: After reset, every register reads zero and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_addr | input | ADDR_W | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pwm_out | output | NCH | One PWM output per channel |

## Verification
The bench builds the block with its defaults: NCH=4 and ADDR_W=8. These values allow four channels to run at once with different dividers and high-time counts, including the 0, 256 and 511 extremes. They also make address 0x40 a legal address whose channel number is out of range, so the out-of-range decode case can be tested. With a divider of 1 the frame boundary falls 512 clocks after the start, so the bench can check a deferred reprogram on both sides of that boundary within a short run.

// File: rtl/pwm_bank_pkg.sv
// Package: field layout of the channel control word and the decoded
// per-channel configuration type shared by the register file and channels.
package pwm_bank_pkg;
    localparam int WORD_W       = 32;
    localparam int EN_BIT       = 31;
    localparam int DUTY_LSB     = 16;
    localparam int DUTY_W       = 9;
    localparam int PRE_LSB      = 0;
    localparam int PRE_W        = 13;
    localparam int FRAME_W      = 8;
    localparam int STRIDE_SHIFT = 4;

    typedef struct packed {
        logic              en;
        logic [DUTY_W-1:0] duty;
        logic [PRE_W-1:0]  pre;
    } chan_cfg_t;
endpackage

// File: rtl/pwm_bank_regs.sv
// Module: channel register file with address decode.
// Holds one decoded control word per channel. Assumes a single-cycle
// write strobe and registers placed at a 16-byte stride from address 0.
module pwm_bank_regs
    import pwm_bank_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [WORD_W-1:0]        bus_wdata,
    output logic [WORD_W-1:0]        bus_rdata,
    output chan_cfg_t [NCH-1:0]      cfg_o
);
    localparam int IDX_W = ADDR_W - STRIDE_SHIFT;

    logic [IDX_W-1:0] idx;
    logic             hit;
    logic             unused_wdata;

    assign idx = bus_addr[ADDR_W-1:STRIDE_SHIFT];
    // Decode: aligned to the stride and inside the channel range
    assign hit = (bus_addr[STRIDE_SHIFT-1:0] == '0) && (int'(idx) < NCH);
    assign unused_wdata = ^{bus_wdata[EN_BIT-1:DUTY_LSB+DUTY_W],
                            bus_wdata[DUTY_LSB-1:PRE_LSB+PRE_W]};

    for (genvar i = 0; i < NCH; i++) begin : g_reg
        // Capture the masked fields of a write addressed to this channel
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_o[i] <= '0;
            end else if (bus_wr && hit && idx == IDX_W'(i)) begin
                cfg_o[i].en   <= bus_wdata[EN_BIT];
                cfg_o[i].duty <= bus_wdata[DUTY_LSB +: DUTY_W];
                cfg_o[i].pre  <= bus_wdata[PRE_LSB +: PRE_W];
            end
        end

        // R1: a write to this channel appears in its fields one cycle later
        p_wr_readback_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == ADDR_W'(i << STRIDE_SHIFT)) |=>
            (cfg_o[i].en == $past(bus_wdata[EN_BIT]) &&
             cfg_o[i].duty == $past(bus_wdata[DUTY_LSB +: DUTY_W]) &&
             cfg_o[i].pre == $past(bus_wdata[PRE_LSB +: PRE_W])));
    end

    // Read mux: repack the selected channel, zero for unmapped addresses
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (hit && idx == IDX_W'(i)) begin
                bus_rdata[EN_BIT]                = cfg_o[i].en;
                bus_rdata[DUTY_LSB +: DUTY_W]    = cfg_o[i].duty;
                bus_rdata[PRE_LSB +: PRE_W]      = cfg_o[i].pre;
            end
        end
    end

    // R2: writes that miss the map leave every register unchanged
    p_miss_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !hit) |=> $stable(cfg_o));
endmodule

// File: rtl/pwm_bank_tick.sv
// Module: tick prescaler.
// Counts input clocks from 0 to limit and pulses tick_o on the last one.
// Assumes limit only changes while clr is high or just as the count wraps.
module pwm_bank_tick
    import pwm_bank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [PRE_W-1:0] limit,
    output logic             tick_o
);
    logic [PRE_W-1:0] cnt;

    assign tick_o = !clr && (cnt == limit);

    // Divider count: held at zero by clr, wraps after reaching limit
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (cnt == limit) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R4: the count never passes its divider limit
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= limit);
    // R3: clear forces the count to zero on the next cycle
    p_clr_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt == '0);
endmodule

// File: rtl/pwm_bank_chan.sv
// Module: one PWM channel.
// Keeps an active copy of duty and divider that reloads only while
// stopped or at a frame wrap, counts 256 ticks per frame, and compares
// the frame position against the active duty. Assumes cfg_i is registered.
module pwm_bank_chan
    import pwm_bank_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  chan_cfg_t cfg_i,
    output logic      pwm_o
);
    logic               running;
    logic               hold;
    logic               tick;
    logic               wrap;
    logic [FRAME_W-1:0] frame_cnt;
    logic [DUTY_W-1:0]  act_duty;
    logic [PRE_W-1:0]   act_pre;

    assign hold = !cfg_i.en || !running;
    assign wrap = tick && (frame_cnt == '1);

    pwm_bank_tick i_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (hold),
        .limit  (act_pre),
        .tick_o (tick)
    );

    // Run flag: one-cycle delayed copy of the enable, gives the load slot
    always_ff @(posedge clk) begin
        if (!rst_n) running <= 1'b0;
        else        running <= cfg_i.en;
    end

    // Frame position: zero while held, advances on every tick
    always_ff @(posedge clk) begin
        if (!rst_n || hold) frame_cnt <= '0;
        else if (tick)      frame_cnt <= frame_cnt + 1'b1;
    end

    // Active settings: follow the register while held, else reload at wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_duty <= '0;
            act_pre  <= '0;
        end else if (hold || wrap) begin
            act_duty <= cfg_i.duty;
            act_pre  <= cfg_i.pre;
        end
    end

    assign pwm_o = running && cfg_i.en && ({1'b0, frame_cnt} < act_duty);

    // R3: a cleared enable parks the frame position at zero
    p_hold_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_i.en |=> frame_cnt == '0);
    // R6: a high phase always begins at the first tick of a frame
    p_rise_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_o) |-> frame_cnt == '0);
    // R7: inside a running frame the active settings do not move
    p_defer_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (running && cfg_i.en && !wrap) |=> ($stable(act_duty) && $stable(act_pre)));
endmodule

// File: rtl/pwm_bank.sv
// Module: top of the multi-channel PWM controller.
// Connects the register file to one channel instance per output.
// Assumes NCH*16 fits in the ADDR_W byte address space.
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NCH-1:0]    pwm_out
);
    chan_cfg_t [NCH-1:0] cfg;

    pwm_bank_regs #(.NCH(NCH), .ADDR_W(ADDR_W)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cfg_o     (cfg)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        pwm_bank_chan i_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .cfg_i (cfg[c]),
            .pwm_o (pwm_out[c])
        );
    end

    // R9: outputs stay low for the cycle right after reset
    p_reset_low_r9: assert property (@(posedge clk)
        !rst_n |=> pwm_out == '0);
endmodule

// File: tb/test_pwm_bank.sv
`timescale 1ns/1ps
module test_pwm_bank;
    localparam int NCH    = 4;
    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    wire  [31:0]       bus_rdata;
    wire  [NCH-1:0]    pwm_out;

    pwm_bank #(.NCH(NCH), .ADDR_W(ADDR_W)) i_pwm_bank (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    always #2.5 clk = ~clk;

    longint cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        longint at;
        int     ch;
        bit     val;
        string  tag;
    } exp_t;
    exp_t exp_q[$];

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Monitor: compare every expected output bit due in this cycle
    always @(negedge clk) begin
        for (int i = exp_q.size() - 1; i >= 0; i--) begin
            if (exp_q[i].at == cyc) begin
                check(pwm_out[exp_q[i].ch] == exp_q[i].val, exp_q[i].tag,
                      32'(pwm_out[exp_q[i].ch]), 32'(exp_q[i].val));
                exp_q.delete(i);
            end
        end
    end

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d,
                             output longint ew);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
        ew = cyc;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // Driver side: expected bit k clocks after the first running edge e1
    task automatic push_wave(int ch, longint e1, int duty, int pre, int k, string tag);
        exp_t it;
        it.at  = e1 + k;
        it.ch  = ch;
        it.val = ((k / (pre + 1)) % 256) < duty;
        it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic wait_until(longint t);
        while (cyc < t) @(negedge clk);
    endtask

    function automatic logic [31:0] word(bit en, int duty, int pre);
        return {en, 6'd0, 9'(duty), 3'd0, 13'(pre)};
    endfunction

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog all-reqs actual=%0d expected=<200000", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        longint e, e0, e1;
        logic [31:0] d;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(pwm_out == '0, "R9 outputs low after reset", 32'(pwm_out), 0);
        for (int c = 0; c < NCH; c++) begin
            bus_read(ADDR_W'(c * 16), d);
            check(d == 0, "R9 register zero after reset", d, 0);
        end

        // R1 masking and R5 saturated duty on channel 1
        bus_write(8'h10, 32'hFFFF_FFFF, e);
        push_wave(1, e + 1, 511, 8191, 0, "R5 duty 511 constant high");
        bus_read(8'h10, d);
        check(d == 32'h81FF_1FFF, "R1 readback masked", d, 32'h81FF_1FFF);
        wait_until(e + 4);
        // R8 writing zero clears and stops
        bus_write(8'h10, 32'h0, e);
        check(pwm_out[1] == 1'b0, "R8 zero write drops output", 32'(pwm_out[1]), 0);
        bus_read(8'h10, d);
        check(d == 0, "R8 zero write clears fields", d, 0);

        // R2 unmapped writes ignored, reads zero
        bus_write(8'h04, word(1, 5, 0), e);
        bus_write(8'h40, word(1, 5, 0), e);
        bus_read(8'h00, d);
        check(d == 0, "R2 misaligned write ignored", d, 0);
        bus_read(8'h04, d);
        check(d == 0, "R2 misaligned read zero", d, 0);
        bus_read(8'h40, d);
        check(d == 0, "R2 out-of-range read zero", d, 0);
        repeat (3) @(negedge clk);
        check(pwm_out == '0, "R2 no channel started", 32'(pwm_out), 0);

        // R6/R5/R4 channel 0: duty 3, divider 1
        bus_write(8'h00, word(1, 3, 1), e0);
        check(pwm_out[0] == 1'b0, "R6 low right after enable edge", 32'(pwm_out[0]), 0);
        e1 = e0 + 1;
        push_wave(0, e1, 3, 1, 0,   "R6 high from first running cycle");
        push_wave(0, e1, 3, 1, 5,   "R5 last high tick");
        push_wave(0, e1, 3, 1, 6,   "R5 first low tick");
        push_wave(0, e1, 3, 1, 300, "R5 low mid frame");
        push_wave(0, e1, 3, 1, 511, "R4 low at frame end");

        // R5 duty 0 on channel 2
        bus_write(8'h20, word(1, 0, 0), e);
        push_wave(2, e + 1, 0, 0, 0,   "R5 duty 0 low");
        push_wave(2, e + 1, 0, 0, 200, "R5 duty 0 stays low");
        bus_read(8'h20, d);
        check(d == 32'h8000_0000, "R1 readback enable only", d, 32'h8000_0000);

        // R5 duty 256 on channel 3
        bus_write(8'h30, word(1, 256, 0), e);
        push_wave(3, e + 1, 256, 0, 255, "R5 duty 256 high at last tick");
        push_wave(3, e + 1, 256, 0, 256, "R5 duty 256 high across wrap");

        // R4 channel 1: duty 2, divider 4
        bus_write(8'h10, word(1, 2, 4), e);
        push_wave(1, e + 1, 2, 4, 9,    "R4 tick spans 5 clocks high");
        push_wave(1, e + 1, 2, 4, 10,   "R4 tick spans 5 clocks low");
        push_wave(1, e + 1, 2, 4, 1279, "R4 period 1280 low before");
        push_wave(1, e + 1, 2, 4, 1280, "R4 period 1280 new frame high");

        // R7 reprogram channel 0 in its first frame: duty 200 deferred
        wait_until(e1 + 20);
        bus_write(8'h00, word(1, 200, 1), e);
        push_wave(0, e1, 3, 1, 100,         "R7 old duty kept mid frame");
        push_wave(0, e1, 200, 1, 512,       "R4 new frame starts at 512");
        push_wave(0, e1, 200, 1, 512 + 100, "R7 new duty after boundary");
        push_wave(0, e1, 200, 1, 512 + 399, "R7 new duty last high");
        push_wave(0, e1, 200, 1, 512 + 400, "R5 new duty first low");

        // R3 stop while high, then restart from tick 0
        wait_until(e1 + 1024 + 10);
        check(pwm_out[0] == 1'b1, "R3 high before stop", 32'(pwm_out[0]), 1);
        bus_write(8'h00, word(0, 200, 1), e);
        check(pwm_out[0] == 1'b0, "R3 low right after stop", 32'(pwm_out[0]), 0);
        bus_read(8'h00, d);
        check(d == word(0, 200, 1), "R1 readback stopped fields", d, word(0, 200, 1));
        repeat (5) @(negedge clk);
        check(pwm_out[0] == 1'b0, "R3 stays low while stopped", 32'(pwm_out[0]), 0);
        bus_write(8'h00, word(1, 200, 1), e);
        push_wave(0, e + 1, 200, 1, 0,   "R3 restart at tick 0 high");
        push_wave(0, e + 1, 200, 1, 399, "R3 restart last high");
        push_wave(0, e + 1, 200, 1, 400, "R3 restart first low");

        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        done = 1;
        summary();
        $finish;
    end
endmodule